// File: doc/BRIEF.md
# Wake Request Aggregator

This block gathers wake events from a bank of general-purpose inputs, a hardware-monitor event line and a grouped interrupt line. It drives a single wake-request pad. Each event is synchronised and edge-detected, then caught in a sticky status bit that software clears by writing 1. The status is qualified twice. First, a status bit ANDed with its wake-enable bit forms a pin-status bit. Second, a pin-status bit ANDed with its pin-enable bit requests the wake output.

The pad can be active-high or active-low, and it can be driven push-pull or open-drain. After reset it is active-low and open-drain, so an idle pad is released. Software sees sixteen 8-bit registers through a simple bus: an address, a write strobe, write data and combinational read data.

Register map:

| Address | Contents |
|---|---|
| 0 | Input status |
| 1 | Monitor status (bit 0) |
| 2 | Group status (bit 3) |
| 3 to 5 | Wake-enable registers, one per status register |
| 6 to 8 | Pin-enable registers |
| 9 to 11 | Pin status (read-only) |
| 12 | Pad control |
| 13 | Interrupt gate (bit 5) |
| 14 | Per-input polarity |
| 15 | Per-input either-edge mode |

Top module: `wake_req_hub`

## Requirements
- R1: After reset every register reads 0, and the pad is released (output-enable 0).
- R2: With its polarity bit (address 14) at 0 and its mode bit (address 15) at 0, an input's rising edge sets its bit in address 0 and its falling edge does not.
- R3: With its polarity bit at 1 and its mode bit at 0, an input's falling edge sets its status bit and its rising edge does not.
- R4: With its mode bit at 1, both edges of an input set its status bit, whatever the polarity bit.
- R5: Writing 1 to a bit of a status register (addresses 0 to 2) clears that bit. Writing 0 leaves it unchanged, and status bits never fall without such a write.
- R6: An event arriving in the same cycle as a write-1 clear of its bit leaves the bit set.
- R7: Pin status at address 9+k reads as status register k ANDed with wake-enable register 3+k.
- R8: The wake request is active exactly when some pin-status bit and its pin-enable bit (address 6+k) are both set.
- R9: Bit 3 of address 2 is set while the grouped interrupt line is high, but only when bit 5 of address 13 is 1. Its wake enable is bit 3 of address 5.
- R10: A rising edge of the monitor line sets bit 0 of address 1.
- R11: Pad control (address 12) bit 0 selects the active level: 1 for high, 0 for low. Bit 7 selects push-pull (1) or open-drain (0). In push-pull mode the output-enable is 1 and the data equals the pad level. In open-drain mode the data is 0 and the output-enable is 1 only while the level is low.
- R12: An input change made between clock edges first shows in status after the third following rising edge, and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 4 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| gpi_evt | input | 8 | General-purpose event inputs |
| hwm_evt | input | 1 | Hardware-monitor event line |
| grp_irq | input | 1 | Grouped interrupt line |
| wake_pad_dout | output | 1 | Pad data |
| wake_pad_oe | output | 1 | Pad output enable |

## Verification
A wrong sticky status bit shows up at the read port on the same cycle it goes wrong. Through the two enable stages, it also reaches the pad pins combinationally. Mistakes in edge selection or synchronisation show up as a status bit that is set, or missing, at the exact third rising edge after an input change. Pad-control faults show up as a wrong output-enable and data pair as soon as the control write lands.

// File: rtl/wake_pkg.sv
package wake_pkg;
  localparam int REG_W    = 8;
  localparam int N_GRP    = 3;
  localparam int ADDR_W   = 4;
  localparam int GRP_BIT  = 3;
  localparam int GATE_BIT = 5;
  localparam int PP_BIT   = 7;
  localparam int POL_BIT  = 0;
  localparam logic [ADDR_W-1:0] A_STAT = 4'd0;
  localparam logic [ADDR_W-1:0] A_WEN  = 4'd3;
  localparam logic [ADDR_W-1:0] A_PEN  = 4'd6;
  localparam logic [ADDR_W-1:0] A_PST  = 4'd9;
  localparam logic [ADDR_W-1:0] A_CTL  = 4'd12;
  localparam logic [ADDR_W-1:0] A_GATE = 4'd13;
  localparam logic [ADDR_W-1:0] A_POL  = 4'd14;
  localparam logic [ADDR_W-1:0] A_MODE = 4'd15;
endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/wake_edge_det.sv
module wake_edge_det #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  input  logic [W-1:0] inv,
  input  logic [W-1:0] both,
  output logic [W-1:0] hit
);
  logic [W-1:0] s_q;
  logic [W-1:0] prev_q;

  wake_sync #(.W(W)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (raw),
    .q    (s_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= s_q;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic rise, fall;
    always_comb begin
      rise = s_q[i] & ~prev_q[i];
      fall = ~s_q[i] & prev_q[i];
      if (both[i])     hit[i] = rise | fall;
      else if (inv[i]) hit[i] = fall;
      else             hit[i] = rise;
    end
  end
endmodule

// File: rtl/wake_pin_drv.sv
module wake_pin_drv (
  input  logic req,
  input  logic act_high,
  input  logic push_pull,
  output logic dout,
  output logic oe
);
  logic level;

  always_comb begin
    level = act_high ? req : ~req;
    if (push_pull) begin
      oe   = 1'b1;
      dout = level;
    end else begin
      oe   = ~level;
      dout = 1'b0;
    end
  end
endmodule

// File: rtl/wake_req_hub.sv
module wake_req_hub
  import wake_pkg::*;
#(
  parameter int GPI_W = 8,
  parameter int HWM_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [GPI_W-1:0]  gpi_evt,
  input  logic [HWM_W-1:0]  hwm_evt,
  input  logic              grp_irq,
  output logic              wake_pad_dout,
  output logic              wake_pad_oe
);
  localparam int SEL_W = REG_W;

  logic rst_meta_n, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  logic [REG_W-1:0] stat_q [N_GRP];
  logic [REG_W-1:0] stat_d [N_GRP];
  logic [REG_W-1:0] wen_q  [N_GRP];
  logic [REG_W-1:0] pen_q  [N_GRP];
  logic [REG_W-1:0] pst    [N_GRP];
  logic [REG_W-1:0] set_v  [N_GRP];
  logic [REG_W-1:0] ctl_q, gate_q, pol_q, mode_q;

  logic [GPI_W-1:0] gpi_hit;
  logic [HWM_W-1:0] hwm_hit;
  logic             grp_s;
  logic             req_any;

  wake_edge_det #(.W(GPI_W)) u_gpi_det (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .raw  (gpi_evt),
    .inv  (pol_q[GPI_W-1:0]),
    .both (mode_q[GPI_W-1:0]),
    .hit  (gpi_hit)
  );

  wake_edge_det #(.W(HWM_W)) u_hwm_det (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .raw  (hwm_evt),
    .inv  ({HWM_W{1'b0}}),
    .both ({HWM_W{1'b0}}),
    .hit  (hwm_hit)
  );

  wake_sync #(.W(1)) u_grp_sync (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .d    (grp_irq),
    .q    (grp_s)
  );

  always_comb begin
    set_v[0] = '0;
    set_v[1] = '0;
    set_v[2] = '0;
    set_v[0][GPI_W-1:0] = gpi_hit;
    set_v[1][HWM_W-1:0] = hwm_hit;
    set_v[2][GRP_BIT]   = grp_s & gate_q[GATE_BIT];
  end

  for (genvar k = 0; k < N_GRP; k++) begin : g_grp
    logic clr_en, wen_en, pen_en;
    assign clr_en = reg_wr && (reg_addr == A_STAT + ADDR_W'(k));
    assign wen_en = reg_wr && (reg_addr == A_WEN  + ADDR_W'(k));
    assign pen_en = reg_wr && (reg_addr == A_PEN  + ADDR_W'(k));

    always_comb begin
      stat_d[k] = (stat_q[k] & ~(clr_en ? reg_wdata : '0)) | set_v[k];
      pst[k]    = stat_q[k] & wen_q[k];
    end

    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n) begin
        stat_q[k] <= '0;
        wen_q[k]  <= '0;
        pen_q[k]  <= '0;
      end else begin
        stat_q[k] <= stat_d[k];
        if (wen_en) wen_q[k] <= reg_wdata;
        if (pen_en) pen_q[k] <= reg_wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ctl_q  <= '0;
      gate_q <= '0;
      pol_q  <= '0;
      mode_q <= '0;
    end else if (reg_wr) begin
      if (reg_addr == A_CTL)  ctl_q  <= reg_wdata;
      if (reg_addr == A_GATE) gate_q <= reg_wdata;
      if (reg_addr == A_POL)  pol_q  <= reg_wdata;
      if (reg_addr == A_MODE) mode_q <= reg_wdata;
    end
  end

  always_comb begin
    req_any = 1'b0;
    for (int k = 0; k < N_GRP; k++) req_any = req_any | (|(pst[k] & pen_q[k]));
  end

  always_comb begin
    case (reg_addr)
      4'd0:    reg_rdata = stat_q[0];
      4'd1:    reg_rdata = stat_q[1];
      4'd2:    reg_rdata = stat_q[2];
      4'd3:    reg_rdata = wen_q[0];
      4'd4:    reg_rdata = wen_q[1];
      4'd5:    reg_rdata = wen_q[2];
      4'd6:    reg_rdata = pen_q[0];
      4'd7:    reg_rdata = pen_q[1];
      4'd8:    reg_rdata = pen_q[2];
      4'd9:    reg_rdata = pst[0];
      4'd10:   reg_rdata = pst[1];
      4'd11:   reg_rdata = pst[2];
      4'd12:   reg_rdata = ctl_q;
      4'd13:   reg_rdata = gate_q;
      4'd14:   reg_rdata = pol_q;
      default: reg_rdata = mode_q;
    endcase
  end

  logic [SEL_W-1:0] stat_gpi_w, stat_grp_w, set_gpi_w;
  assign stat_gpi_w = stat_q[0];
  assign stat_grp_w = stat_q[2];
  assign set_gpi_w  = set_v[0];

  wake_pin_drv u_drv (
    .req      (req_any),
    .act_high (ctl_q[POL_BIT]),
    .push_pull(ctl_q[PP_BIT]),
    .dout     (wake_pad_dout),
    .oe       (wake_pad_oe)
  );
endmodule

// File: rtl/wake_req_hub_chk.sv
module wake_req_hub_chk
  import wake_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic [REG_W-1:0]  reg_wdata,
  input logic [REG_W-1:0]  stat_gpi,
  input logic [REG_W-1:0]  set_gpi,
  input logic [REG_W-1:0]  stat_grp,
  input logic [REG_W-1:0]  gate,
  input logic [REG_W-1:0]  ctl,
  input logic              pad_dout,
  input logic              pad_oe
);
  // R11
  od_no_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl[PP_BIT] |-> !pad_dout);

  // R11
  pp_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl[PP_BIT] |-> pad_oe);

  // R5
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_STAT) |=>
      ((stat_gpi & $past(reg_wdata) & ~$past(set_gpi)) == '0));

  // R5
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == A_STAT) |=> ((~stat_gpi & $past(stat_gpi)) == '0));

  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_gpi) |=> ((stat_gpi & $past(set_gpi)) == $past(set_gpi)));

  // R9
  grp_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate[GATE_BIT] && !stat_grp[GRP_BIT]) |=> !stat_grp[GRP_BIT]);
endmodule

bind wake_req_hub wake_req_hub_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_addr (reg_addr),
  .reg_wr   (reg_wr),
  .reg_wdata(reg_wdata),
  .stat_gpi (stat_gpi_w),
  .set_gpi  (set_gpi_w),
  .stat_grp (stat_grp_w),
  .gate     (gate_q),
  .ctl      (ctl_q),
  .pad_dout (wake_pad_dout),
  .pad_oe   (wake_pad_oe)
);

// File: tb/wake_req_hub_tb.sv
module wake_req_hub_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] reg_addr;
  logic       reg_wr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic [7:0] gpi_evt;
  logic       hwm_evt;
  logic       grp_irq;
  logic       wake_pad_dout, wake_pad_oe;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  wake_req_hub u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .gpi_evt(gpi_evt),
    .hwm_evt(hwm_evt), .grp_irq(grp_irq),
    .wake_pad_dout(wake_pad_dout), .wake_pad_oe(wake_pad_oe)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    logic [7:0] v;
    rst_n = 1'b0; reg_addr = '0; reg_wr = 1'b0; reg_wdata = '0;
    gpi_evt = '0; hwm_evt = 1'b0; grp_irq = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), v);
      check("R1 reg", v, 8'h00);
    end
    check("R1 pad", {6'd0, wake_pad_oe, wake_pad_dout}, 8'h00);

    // R12 latency: change between edges, visible after the third edge
    @(negedge clk);
    gpi_evt[0] = 1'b1;
    @(negedge clk); @(negedge clk);
    rd(4'd0, v); check("R12 early", v, 8'h00);
    @(negedge clk);
    rd(4'd0, v); check("R12 on time", v, 8'h01);
    gpi_evt[0] = 1'b0; settle();
    wr(4'd0, 8'hFF);

    // R2 R3 R4 sweep over inputs, polarity and mode
    for (int i = 0; i < 8; i++) begin
      for (int p = 0; p < 2; p++) begin
        for (int m = 0; m < 2; m++) begin
          wr(4'd14, 8'(p) << i);
          wr(4'd15, 8'(m) << i);
          settle();
          wr(4'd0, 8'hFF);
          gpi_evt[i] = 1'b1; settle();
          rd(4'd0, v);
          check(m ? "R4 rise" : (p ? "R3 rise" : "R2 rise"), v,
                (m == 1 || p == 0) ? (8'h01 << i) : 8'h00);
          wr(4'd0, 8'hFF);
          gpi_evt[i] = 1'b0; settle();
          rd(4'd0, v);
          check(m ? "R4 fall" : (p ? "R3 fall" : "R2 fall"), v,
                (m == 1 || p == 1) ? (8'h01 << i) : 8'h00);
          wr(4'd0, 8'hFF);
        end
      end
    end
    wr(4'd14, 8'h00); wr(4'd15, 8'h00);

    // R5 write 0 keeps, write 1 clears only that bit
    gpi_evt = 8'h05; settle();
    wr(4'd0, 8'h00);
    rd(4'd0, v); check("R5 write0", v, 8'h05);
    wr(4'd0, 8'h04);
    rd(4'd0, v); check("R5 write1", v, 8'h01);
    gpi_evt = 8'h00; settle();
    wr(4'd0, 8'hFF);

    // R6 event coincident with a clear
    wr(4'd15, 8'h02);
    gpi_evt[1] = 1'b1; settle();
    @(negedge clk);
    gpi_evt[1] = 1'b0;
    @(negedge clk); @(negedge clk);
    reg_addr = 4'd0; reg_wdata = 8'h02; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    rd(4'd0, v); check("R6 set wins", v, 8'h02);
    wr(4'd0, 8'hFF); wr(4'd15, 8'h00);

    // R7 R8 qualification sweep on input 0
    gpi_evt[0] = 1'b1; settle();
    for (int we = 0; we < 2; we++) begin
      for (int pe = 0; pe < 2; pe++) begin
        wr(4'd3, 8'(we)); wr(4'd6, 8'(pe));
        rd(4'd9, v); check("R7 pin status", v, 8'(we));
        check("R8 pad", {7'd0, wake_pad_oe}, 8'(we & pe));
      end
    end

    // R11 pad sweep: level, drive, request
    wr(4'd3, 8'h01);
    for (int ah = 0; ah < 2; ah++) begin
      for (int pp = 0; pp < 2; pp++) begin
        for (int rq = 0; rq < 2; rq++) begin
          logic lvl;
          wr(4'd12, (8'(pp) << 7) | 8'(ah));
          wr(4'd6, 8'(rq));
          lvl = ah[0] ? rq[0] : ~rq[0];
          check("R11 pad", {6'd0, wake_pad_oe, wake_pad_dout},
                pp ? {6'd0, 1'b1, lvl} : {6'd0, ~lvl, 1'b0});
        end
      end
    end
    wr(4'd12, 8'h00); wr(4'd6, 8'h00); wr(4'd3, 8'h00);
    gpi_evt[0] = 1'b0; settle();
    wr(4'd0, 8'hFF);

    // R10 monitor line
    hwm_evt = 1'b1; settle();
    rd(4'd1, v); check("R10 monitor", v, 8'h01);
    wr(4'd4, 8'h01); wr(4'd7, 8'h01);
    check("R10 pad", {7'd0, wake_pad_oe}, 8'h01);
    hwm_evt = 1'b0; wr(4'd1, 8'h01); settle();
    rd(4'd1, v); check("R10 cleared", v, 8'h00);

    // R9 grouped interrupt and its gate
    grp_irq = 1'b1; settle();
    rd(4'd2, v); check("R9 gated off", v, 8'h00);
    wr(4'd13, 8'h20); settle();
    rd(4'd2, v); check("R9 gated on", v, 8'h08);
    wr(4'd5, 8'h08);
    rd(4'd11, v); check("R9 pin status", v, 8'h08);
    grp_irq = 1'b0; settle();
    wr(4'd2, 8'h08);
    rd(4'd2, v); check("R9 cleared", v, 8'h00);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule